// File: doc/BRIEF.md
# Segment insertion scan cell

This block is one element of a reconfigurable serial test-data chain. It always places a single control bit of its own on the scan path. Behind that bit it has a hierarchical port pair: a to-segment serial output and a from-segment serial input. Whether the segment hanging on that pair joins the path is set by a one-bit state register. That register is loaded from the control bit on an update pulse, so the scan length can change from one scan to the next but never during a shift.

A sample instrument register is built into the block. It is a shift register with a parallel update latch and a parallel capture input, and its serial input is the from-segment port. When the to-segment output is looped back to the from-segment input, opening the cell inserts the instrument into the path. Further segments can also be chained through the port pair. Shift, capture, update and select arrive as plain inputs from an external test controller. Bits travel LSB first.

Top module: `seg_insert_cell`

## Requirements
- R1: After reset the state is closed, the cell bit is 0, `so` is 0 and `inst_out` is 0.
- R2: While closed, the path is exactly one bit long. After each qualified shift clock, `so` equals the `si` value of the previous shift.
- R3: While open, with `seg_out` looped to `seg_in`, the path is INST_W+1 bits long. Of a scan of INST_W+1 bits, the first INST_W bits out are the instrument shift register, LSB first, and the last bit out is the cell bit. The first INST_W bits in land in the instrument register, LSB first, and the last bit in lands in the cell bit.
- R4: The state register takes the cell bit only on a qualified update (1 = open, 0 = closed). Shifting a new control bit does not change the path length before that update.
- R5: A qualified capture loads the cell bit with the current state (1 open, 0 closed). While open, it also loads the instrument shift register from `inst_in`. Capture takes priority over shift.
- R6: A qualified update while open copies the instrument shift register to `inst_out`. An update while closed leaves `inst_out` unchanged.
- R7: With `sel` low, shift, capture and update have no effect on any register.
- R8: While closed, the instrument shift register holds its contents across shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Qualifies shift, capture and update |
| capture_en | input | 1 | Capture phase |
| shift_en | input | 1 | Shift phase |
| update_en | input | 1 | Update phase |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| seg_out | output | 1 | Serial data to the hierarchical segment |
| seg_in | input | 1 | Serial data from the hierarchical segment |
| inst_in | input | INST_W | Instrument results, loaded on capture |
| inst_out | output | INST_W | Instrument command, latched on update |

## Verification
The bench sweeps every instrument value through an open scan. Each value is checked in both directions, which covers bit ordering, path length and the overlap of one access's results with the next access's commands. A swapped or off-by-one chain would misplace bits, and a cell that applied its new state during the shift would shorten the path too early, dropping the cell bit out of position. Further scans check the following:
- A one-bit passthrough while closed, which a design that leaked the segment onto the path would lengthen.
- Retention of the instrument contents while closed, which a design that shifted the instrument regardless of state would lose.
- The unchanged `inst_out` after a closed update.
- Full inertness while deselected, which a design with an unqualified control would break by moving the path or the outputs.

// File: rtl/seg_insert_cell.sv
module seg_insert_cell #(
  parameter int INST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              capture_en,
  input  logic              shift_en,
  input  logic              update_en,
  input  logic              si,
  output logic              so,
  output logic              seg_out,
  input  logic              seg_in,
  input  logic [INST_W-1:0] inst_in,
  output logic [INST_W-1:0] inst_out
);

  logic              cell_q;
  logic              state_q;
  logic [INST_W-1:0] sr_q;
  logic [INST_W-1:0] out_q;

  wire do_cap   = sel && capture_en;
  wire do_shift = sel && shift_en && !capture_en;
  wire do_upd   = sel && update_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cell_q <= 1'b0;
    else if (do_cap)   cell_q <= state_q;
    else if (do_shift) cell_q <= si;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      state_q <= 1'b0;
    else if (do_upd) state_q <= cell_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   sr_q <= '0;
    else if (state_q && do_cap)   sr_q <= inst_in;
    else if (state_q && do_shift) sr_q <= {seg_in, sr_q[INST_W-1:1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 out_q <= '0;
    else if (state_q && do_upd) out_q <= sr_q;

  assign seg_out  = cell_q;
  assign so       = state_q ? sr_q[0] : cell_q;
  assign inst_out = out_q;

  assert_closed_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_shift && !update_en && !state_q) |=> (so == $past(si)));

  assert_update_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !do_upd |=> (state_q == $past(state_q)));

  assert_capture_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_cap |=> (seg_out == $past(state_q)));

  assert_closed_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !state_q |=> $stable(inst_out));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(seg_out) && $stable(inst_out) && $stable(so)));

endmodule

// File: tb/seg_insert_cell_test.sv
`timescale 1ns/1ps
module seg_insert_cell_test;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, sel = 0, capture_en = 0, shift_en = 0, update_en = 0, si = 0;
  logic so, seg_out;
  logic [W-1:0] inst_in = '0, inst_out;
  int checks = 0, errors = 0;
  logic [15:0] dout;

  seg_insert_cell #(.INST_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .si(si), .so(so), .seg_out(seg_out), .seg_in(seg_out),
    .inst_in(inst_in), .inst_out(inst_out));

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic scan(input int n, input logic [15:0] din, input bit cap, output logic [15:0] q);
    q = '0;
    if (cap) begin
      capture_en = 1; @(negedge clk); capture_en = 0;
    end
    shift_en = 1;
    for (int i = 0; i < n; i++) begin
      si = din[i]; #0.1 q[i] = so; @(negedge clk);
    end
    shift_en = 0; update_en = 1; @(negedge clk); update_en = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 so", {15'd0, so}, 16'd0);
    check("R1 inst_out", {8'd0, inst_out}, 16'd0);
    rst_n = 1; sel = 1; @(negedge clk);

    scan(1, 16'd0, 1, dout);
    check("R5 closed state read", dout[0], 1'b0);
    scan(4, 16'b1011, 1, dout);
    check("R2 closed passthrough", dout[3:0], 4'b0110);
    check("R6 closed update", {8'd0, inst_out}, 16'd0);

    for (int v = 0; v < 256; v++) begin
      inst_in = W'(v * 7 + 3);
      scan(W + 1, {7'd0, 1'b1, 8'(v)}, 1, dout);
      check("R3 open data out", {8'd0, dout[W-1:0]}, {8'd0, inst_in});
      check("R5 open state read", dout[W], 1'b1);
      check("R6 open update", {8'd0, inst_out}, 16'(v));
    end

    inst_in = 8'h3C;
    scan(W + 1, {7'd0, 1'b0, 8'h96}, 1, dout);
    check("R4 long path until update", dout[W:0], {7'd0, 1'b1, 8'h3C});
    check("R6 update before close", {8'd0, inst_out}, 16'h0096);

    scan(3, 16'b010, 0, dout);
    check("R4 closed after update", dout[2:0], 3'b100);
    check("R6 closed leaves inst_out", {8'd0, inst_out}, 16'h0096);

    sel = 0; shift_en = 1; si = 1; update_en = 1;
    for (int c = 0; c < 4; c++) begin
      capture_en = c[0];
      @(negedge clk);
      check("R7 so held", {15'd0, so}, 16'd0);
      check("R7 inst_out held", {8'd0, inst_out}, 16'h0096);
    end
    shift_en = 0; update_en = 0; capture_en = 0; si = 0; sel = 1;
    @(negedge clk);

    scan(1, 16'd1, 1, dout);
    check("R7 state held closed", dout[0], 1'b0);
    scan(W + 1, {7'd0, 1'b1, 8'h00}, 0, dout);
    check("R8 instrument held while closed", {8'd0, dout[W-1:0]}, 16'h0096);
    check("R3 cell bit last", dout[W], 1'b1);
    check("R6 reopen update", {8'd0, inst_out}, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule